// File: doc/BRIEF.md
# RGB Backlight PWM Dimming Unit

This unit drives the red, green and blue LED backlight strings of a display through three pulse-width-modulated outputs. For each colour it receives a 6-bit brightness level from an upstream stage that works out how far the backlight can be dimmed. That stage lowers the backlight while it raises panel transmittance. The levels are first latched into staging registers. A shared free-running 6-bit phase counter, paced by a programmable clock-enable divider, is then compared against one active duty register per colour.

A new set of levels must not light up before the matching rescaled pixel data reaches the panel. If it did, the viewer would see a frame with mismatched backlight and transmittance. For this reason the staged levels are promoted to the active registers only on an alignment strobe from the pixel pipeline. The promotion also waits for the end of a complete PWM period, so that no period is ever cut short or stretched. A scaling-enable input, when low, forces all three outputs to full brightness at once.

Top module: `rgb_backlight_dimmer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the phase counter, staged levels and active duty values are all zero. Each output therefore equals the inverse of `scale_en`.
- R2: On a clock edge where `lvl_valid` is high, `lvl_r`, `lvl_g` and `lvl_b` are captured into the staging registers. Capturing alone never changes a PWM output.
- R3: With `scale_en` high, an output is high exactly when the phase counter value is strictly less than that channel's active duty value.
- R4: A divider tick occurs whenever the divider count has reached `div_ratio`, so ticks come every `div_ratio`+1 clocks. The phase counter advances by one, modulo 64, only on a tick. One PWM period therefore lasts 64×(`div_ratio`+1) clocks.
- R5: The active duty values take the staged values only at the period boundary, which is a tick while the phase is 63. This happens only if an alignment request is pending or `align_stb` is high in that cycle. At all other times the active values hold.
- R6: An `align_stb` pulse in the middle of a period is remembered until the next period boundary and consumed there. Levels captured with no later strobe never reach the outputs.
- R7: A duty value of 0 keeps the output low for the whole period. A value of 63 keeps it high for 63 of the 64 phases, and it is always low at phase 63.
- R8: With `scale_en` low, all three outputs are high in that same cycle, whatever the levels are. The counter and the registers keep running underneath.
- R9: The three channels hold separate duty values. Within one period, each channel's high time is its own level × (`div_ratio`+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| scale_en | input | 1 | 1 = dimming active, 0 = force full brightness |
| lvl_valid | input | 1 | Capture the three level inputs this cycle |
| lvl_r | input | LVL_W | Red brightness level |
| lvl_g | input | LVL_W | Green brightness level |
| lvl_b | input | LVL_W | Blue brightness level |
| align_stb | input | 1 | Pixel pipeline alignment strobe; requests promotion of staged levels |
| div_ratio | input | DIV_W | Divider terminal count; tick period is div_ratio+1 clocks |
| pwm_r | output | 1 | Red backlight PWM |
| pwm_g | output | 1 | Green backlight PWM |
| pwm_b | output | 1 | Blue backlight PWM |

## Verification
The hardest situation to reach is the interaction between captures, strobes and the period boundary. Examples are a strobe arriving long before the boundary, a strobe in the exact boundary cycle, and a capture with no strobe that must stay invisible. All three depend on where the phase counter is, and the ports do not show it. The stimulus places strobes at arbitrary clock offsets and also holds `align_stb` high across the boundary. It also changes `div_ratio` while the unit runs. A cycle-accurate scoreboard tracks the phase from reset and predicts every output sample. On top of that, the high-time count over a full period shows which levels were actually promoted.

// File: rtl/bl_dim_pkg.sv
package bl_dim_pkg;

    localparam int unsigned CH_N   = 3;
    localparam int unsigned LVL_W  = 6;

    typedef enum logic [1:0] {
        CH_RED = 2'd0,
        CH_GRN = 2'd1,
        CH_BLU = 2'd2
    } ch_e;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef lvl_t [CH_N-1:0]  lvl_vec_t;

    // pacing information shared between the counter and the level bank
    typedef struct packed {
        logic tick;   // clock-enable for the phase counter
        logic wrap;   // tick while phase is at its last value
    } pace_t;

    localparam lvl_t PHASE_LAST = {LVL_W{1'b1}};

    function automatic logic duty_on(input lvl_t phase, input lvl_t duty,
                                     input logic enable);
        return !enable || (phase < duty);
    endfunction

endpackage

// File: rtl/bl_pace.sv
module bl_pace
    import bl_dim_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_ratio,
    output lvl_t             phase,
    output pace_t            pace
);

    logic [DIV_W-1:0] div_cnt;

    always_comb begin
        pace.tick = (div_cnt >= div_ratio);
        pace.wrap = pace.tick && (phase == PHASE_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            phase   <= '0;
        end else if (pace.tick) begin
            div_cnt <= '0;
            phase   <= phase + 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pace.tick |=> $stable(phase)); // R4
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        pace.tick |=> (phase == lvl_t'($past(phase) + 1'b1))); // R4

endmodule

// File: rtl/bl_level_bank.sv
module bl_level_bank
    import bl_dim_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl_valid,
    input  lvl_vec_t lvl_in,
    input  logic     align_stb,
    input  pace_t    pace,
    output lvl_vec_t active
);

    lvl_vec_t staged;
    logic     pending;
    logic     commit;

    assign commit = pace.wrap && (pending || align_stb);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (commit) begin
            pending <= 1'b0;
        end else if (align_stb) begin
            pending <= 1'b1;
        end
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                staged[c] <= '0;
                active[c] <= '0;
            end else begin
                if (lvl_valid) staged[c] <= lvl_in[c];
                if (commit)    active[c] <= staged[c];
            end
        end
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pace.wrap |=> $stable(active)); // R5
    AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active == $past(staged))); // R5
    AST_PEND_DROP: assert property (@(posedge clk) disable iff (rst)
        commit |=> !pending); // R6
    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (rst)
        (pending && !pace.wrap) |=> pending); // R6

endmodule

// File: rtl/bl_pwm_cmp.sv
module bl_pwm_cmp
    import bl_dim_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scale_en,
    input  lvl_t phase,
    input  lvl_t duty,
    output logic pwm
);

    assign pwm = duty_on(phase, duty, scale_en);

    AST_ZERO_DARK: assert property (@(posedge clk) disable iff (rst)
        (scale_en && duty == '0) |-> !pwm); // R7
    AST_LAST_DARK: assert property (@(posedge clk) disable iff (rst)
        (scale_en && phase == PHASE_LAST) |-> !pwm); // R7

endmodule

// File: rtl/rgb_backlight_dimmer.sv
module rgb_backlight_dimmer
    import bl_dim_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scale_en,
    input  logic             lvl_valid,
    input  logic [LVL_W-1:0] lvl_r,
    input  logic [LVL_W-1:0] lvl_g,
    input  logic [LVL_W-1:0] lvl_b,
    input  logic             align_stb,
    input  logic [DIV_W-1:0] div_ratio,
    output logic             pwm_r,
    output logic             pwm_g,
    output logic             pwm_b
);

    lvl_t               phase;
    pace_t              pace;
    lvl_vec_t           lvl_in;
    lvl_vec_t           active;
    logic [CH_N-1:0]    pwm_vec;

    always_comb begin
        lvl_in[CH_RED] = lvl_r;
        lvl_in[CH_GRN] = lvl_g;
        lvl_in[CH_BLU] = lvl_b;
    end

    bl_pace #(.DIV_W(DIV_W)) u_pace (
        .clk       (clk),
        .rst       (rst),
        .div_ratio (div_ratio),
        .phase     (phase),
        .pace      (pace)
    );

    bl_level_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .lvl_valid (lvl_valid),
        .lvl_in    (lvl_in),
        .align_stb (align_stb),
        .pace      (pace),
        .active    (active)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_cmp
        bl_pwm_cmp u_cmp (
            .clk      (clk),
            .rst      (rst),
            .scale_en (scale_en),
            .phase    (phase),
            .duty     (active[c]),
            .pwm      (pwm_vec[c])
        );
    end

    assign pwm_r = pwm_vec[CH_RED];
    assign pwm_g = pwm_vec[CH_GRN];
    assign pwm_b = pwm_vec[CH_BLU];

    AST_FULL_ON: assert property (@(posedge clk) disable iff (rst)
        !scale_en |-> (pwm_r && pwm_g && pwm_b)); // R8
    AST_SPLIT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (scale_en && pwm_r && !pwm_g) |-> (active[CH_RED] > active[CH_GRN])); // R9

endmodule

// File: tb/sim_rgb_backlight_dimmer.sv
`timescale 1ns/100ps
module sim_rgb_backlight_dimmer;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          scale_en;
    logic          lvl_valid;
    logic [5:0]    lvl_r, lvl_g, lvl_b;
    logic          align_stb;
    logic [DW-1:0] div_ratio;
    logic          pwm_r, pwm_g, pwm_b;

    int checks   = 0;
    int failures = 0;
    string cur_req = "R1";
    bit done = 0;

    typedef struct {
        logic [2:0] exp;
        string      req;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2 clk = ~clk;   // 250 MHz

    rgb_backlight_dimmer #(.DIV_W(DW)) u0 (
        .clk(clk), .rst(rst), .scale_en(scale_en), .lvl_valid(lvl_valid),
        .lvl_r(lvl_r), .lvl_g(lvl_g), .lvl_b(lvl_b), .align_stb(align_stb),
        .div_ratio(div_ratio), .pwm_r(pwm_r), .pwm_g(pwm_g), .pwm_b(pwm_b)
    );

    // reference state built from the requirements
    int         m_div;
    int         m_ph;
    int         m_stg [3];
    int         m_act [3];
    bit         m_pend;

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // predictor: state update at each edge (inputs are stable there)
    initial begin
        forever begin
            @(posedge clk);
            if (rst) begin
                m_div = 0; m_ph = 0; m_pend = 0;
                for (int c = 0; c < 3; c++) begin m_stg[c] = 0; m_act[c] = 0; end
            end else begin
                bit tk, wr, cm;
                tk = (m_div >= int'(div_ratio));
                wr = tk && (m_ph == 63);
                cm = wr && (m_pend || align_stb);
                if (cm) for (int c = 0; c < 3; c++) m_act[c] = m_stg[c];
                if (lvl_valid) begin
                    m_stg[0] = int'(lvl_r); m_stg[1] = int'(lvl_g); m_stg[2] = int'(lvl_b);
                end
                m_pend = cm ? 1'b0 : (m_pend | align_stb);
                if (tk) begin m_div = 0; m_ph = (m_ph + 1) % 64; end
                else m_div = m_div + 1;
            end
            // push expectation after the driver has settled this cycle's inputs
            #1.5;
            begin
                sb_item_t it;
                for (int c = 0; c < 3; c++)
                    it.exp[c] = !scale_en || (m_ph < m_act[c]);
                it.req = cur_req;
                sb_q.push_back(it);
            end
        end
    end

    // monitor: compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.req, int'({pwm_b, pwm_g, pwm_r}), int'(it.exp), "pwm{b,g,r}");
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load(int r, int g, int b);
        lvl_r = 6'(r); lvl_g = 6'(g); lvl_b = 6'(b); lvl_valid = 1'b1;
        step(1);
        lvl_valid = 1'b0;
    endtask

    task automatic strobe();
        align_stb = 1'b1;
        step(1);
        align_stb = 1'b0;
    endtask

    task automatic count_high(int n, output int hr, output int hg, output int hb);
        hr = 0; hg = 0; hb = 0;
        repeat (n) begin
            @(negedge clk);
            hr += int'(pwm_r); hg += int'(pwm_g); hb += int'(pwm_b);
        end
        @(posedge clk); #1;
    endtask

    initial begin
        int hr, hg, hb;
        rst = 1; scale_en = 1; lvl_valid = 0; align_stb = 0; div_ratio = '0;
        lvl_r = 0; lvl_g = 0; lvl_b = 0;
        step(3);
        // R1: reset state visible at the outputs
        @(negedge clk);
        check("R1", int'({pwm_b, pwm_g, pwm_r}), 0, "outputs in reset");
        step(1);
        rst = 0;
        step(1);
        check("R1", int'({pwm_b, pwm_g, pwm_r}), 0, "outputs after reset");

        // R2/R6: capture without strobe stays invisible
        cur_req = "R2";
        load(20, 40, 63);
        count_high(200, hr, hg, hb);
        check("R2", hr + hg + hb, 0, "high count with no strobe");

        // R5/R6: strobe in mid-period, remembered to boundary
        cur_req = "R6";
        step(17);
        strobe();
        step(140);
        cur_req = "R3";
        count_high(64, hr, hg, hb);
        check("R9", hr, 20, "red high time");
        check("R3", hg, 40, "green high time");
        check("R7", hb, 63, "blue high time at duty 63");

        // R5: strobe held across boundary; new levels 0,1,62
        cur_req = "R5";
        load(0, 1, 62);
        align_stb = 1'b1;
        step(70);
        align_stb = 1'b0;
        step(64);
        cur_req = "R7";
        count_high(64, hr, hg, hb);
        check("R7", hr, 0, "red high time at duty 0");
        check("R5", hg, 1, "green high time");
        check("R5", hb, 62, "blue high time");

        // R4: slower pacing
        cur_req = "R4";
        div_ratio = 8'd2;
        step(400);
        count_high(192, hr, hg, hb);
        check("R4", hr, 0, "red high, ratio 2");
        check("R4", hg, 3, "green high, ratio 2");
        check("R4", hb, 186, "blue high, ratio 2");

        // R6: captured again, no strobe: old levels kept
        cur_req = "R6";
        load(5, 5, 5);
        step(400);
        count_high(192, hr, hg, hb);
        check("R6", hg, 3, "green unchanged without strobe");
        check("R6", hb, 186, "blue unchanged without strobe");

        // R8: scaling off forces full brightness
        cur_req = "R8";
        scale_en = 1'b0;
        count_high(50, hr, hg, hb);
        check("R8", hr, 50, "red forced on");
        check("R8", hg, 50, "green forced on");
        check("R8", hb, 50, "blue forced on");
        scale_en = 1'b1;
        cur_req = "R3";
        step(200);

        // R1: reset mid-run clears everything
        cur_req = "R1";
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        count_high(64, hr, hg, hb);
        check("R1", hr + hg + hb, 0, "outputs dark after re-reset");

        step(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule